// File: doc/BRIEF.md
# Dual 40-bit Accumulator ALU

This block is the single-cycle arithmetic stage of a fixed-point signal-processing datapath. It keeps two 40-bit accumulators, called A and B, and reads two 32-bit operand registers, X and Y, from its inputs. Each operand register is made of a low 16-bit half and a high 16-bit half. A packed 40-bit product from the multiplier is also an input. Each cycle, a 5-bit operation code, a destination bit and a 4-bit source code pick one operation. The operation is performed on the chosen accumulator, and the result is written back on the clock edge when the enable input is high. The same edge updates a 4-bit status nibble.

Before any arithmetic, each operand is aligned to the 40-bit accumulator format according to its type. A 16-bit half is sign-extended and placed in the middle word, bits 31..16. A full 32-bit register is sign-extended from bit 31. The accumulators and the product are used as they are, all 40 bits. Increment and decrement can step either bit 0 or bit 16. Round uses round-half-to-even at bit 16. The logical operations change only the middle word.

Top module: `dual_acc_alu`

## Requirements
- R1: While `rst_n` is low, both accumulators and the `flags` output are zero.
- R2: When `en` is low, or when `op` is an unused code (18 to 31), no accumulator and no flag changes on the clock edge.
- R3: ADD (`op`=0) writes dst+src and SUB (`op`=2) writes dst-src. The destination is A when `dst`=0 and B when `dst`=1. Sources by `src` code:
  - 0 to 3 (low half of X, low half of Y, high half of X, high half of Y): sign-extended from 16 bits, then shifted left by 16.
  - 4 and 5 (full X, full Y): sign-extended from bit 31, not shifted.
  - 6 and 7: accumulator A and accumulator B.
  - 8: the product.
  - 9 to 15: zero.
- R4: ADD-LOW (`op`=1) adds the `src` operand to the destination. For `src` 0 and 1 that operand is the low half of X or Y, zero-extended and not shifted. For any other `src` code it is zero.
- R5: MOVE (`op`=4) writes the aligned source alone (0+src) to the destination.
- R6: COMPARE (`op`=3) computes dst-src and updates the flags from that difference. Neither accumulator is written.
- R7: INCREMENT (`op`=5) adds 1. INCREMENT-MIDDLE (`op`=6) adds 0x10000. DECREMENT (`op`=7) subtracts 1. DECREMENT-MIDDLE (`op`=8) subtracts 0x10000. In every case all 40 bits of the destination are updated.
- R8: ABSOLUTE (`op`=9) negates the destination only when its bit 39 is set. NEGATE (`op`=10) writes 0-dst.
- R9: ROUND (`op`=11) adds 0x8000 and then clears bits 15..0. When bits 15..0 are exactly 0x8000 and bit 16 is 0, the added value is 0 instead of 0x8000.
- R10: CLEAR (`op`=12) writes zero to the destination. TEST (`op`=13) sets the flags from the destination value and writes nothing.
- R11: NOT (`op`=14), AND (`op`=15), OR (`op`=16) and XOR (`op`=17) act on bits 31..16 of the destination only, and bits 39..32 and 15..0 keep their values. The 16-bit second operand depends on `src`:
  - 0 to 3: the low half of X, the low half of Y, the high half of X or the high half of Y.
  - 6 and 7: bits 31..16 of A or of B.
  - any other code: zero.
- R12: After every operation other than an unused code, `flags` is computed from the 40-bit result:
  - bit 0 (Z) is set when the result is zero.
  - bit 1 (N) is bit 39 of the result.
  - bit 2 (E) is set when bits 39..31 are not all equal.
  - bit 3 (U) is set when bit 31 equals bit 30.
- R13: Results wrap modulo 2^40 without saturation. The accumulator that is not the destination never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Perform the selected operation on this edge |
| op | input | 5 | Operation code |
| dst | input | 1 | Destination accumulator: 0 = A, 1 = B |
| src | input | 4 | Source operand code |
| x_in | input | 32 | Operand register X |
| y_in | input | 32 | Operand register Y |
| prod_in | input | 40 | Packed product value |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| flags | output | 4 | Status: {U, E, N, Z} |

## Verification
Random operation sequences use random operand values with mixed signs. These sequences separate the three alignment rules, because a wrong shift or a wrong sign extension changes the middle or upper bytes. Directed cases load chosen accumulator values through MOVE. They then check the four rounding positions below and above the halfway point, with bit 16 both clear and set. They also check increment across the top of the positive range, which shows whether the result wraps. Enable-low cycles and unused codes, mixed into the random stream, show whether any state moves when it must not. Compare and test steps show whether a flag-only operation also writes an accumulator.

// File: rtl/dual_acc_alu_pkg.sv
package dual_acc_alu_pkg;
  localparam int ACC_W  = 40;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;
  localparam int OP_W   = 5;
  localparam int SRC_W  = 4;
  localparam int FLG_W  = 4;
  localparam int EXT_W  = ACC_W - REG_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDL = 5'd1,  OP_SUB  = 5'd2,  OP_CMP  = 5'd3,
    OP_MOVE = 5'd4,  OP_INC  = 5'd5,  OP_INCM = 5'd6,  OP_DEC  = 5'd7,
    OP_DECM = 5'd8,  OP_ABS  = 5'd9,  OP_NEG  = 5'd10, OP_RND  = 5'd11,
    OP_CLR  = 5'd12, OP_TST  = 5'd13, OP_NOT  = 5'd14, OP_AND  = 5'd15,
    OP_OR   = 5'd16, OP_XOR  = 5'd17
  } alu_op_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_XL = 4'd0, SRC_YL = 4'd1, SRC_XH = 4'd2, SRC_YH = 4'd3,
    SRC_X  = 4'd4, SRC_Y  = 4'd5, SRC_A  = 4'd6, SRC_B  = 4'd7,
    SRC_P  = 4'd8
  } alu_src_e;
endpackage

// File: rtl/dual_acc_alu_align.sv
module dual_acc_alu_align
  import dual_acc_alu_pkg::*;
(
  input  logic [SRC_W-1:0]  src,
  input  logic [REG_W-1:0]  x_in,
  input  logic [REG_W-1:0]  y_in,
  input  logic [ACC_W-1:0]  prod_in,
  input  logic [ACC_W-1:0]  acc_a,
  input  logic [ACC_W-1:0]  acc_b,
  output logic [ACC_W-1:0]  src_full,
  output logic [ACC_W-1:0]  src_low,
  output logic [HALF_W-1:0] src_mid
);
  localparam int MID_EXT = ACC_W - REG_W;

  function automatic logic [ACC_W-1:0] half_up(input logic [HALF_W-1:0] h);
    return {{MID_EXT{h[HALF_W-1]}}, h, {HALF_W{1'b0}}};
  endfunction

  always_comb begin
    src_full = '0;
    src_low  = '0;
    src_mid  = '0;
    case (src)
      SRC_XL: begin
        src_full = half_up(x_in[HALF_W-1:0]);
        src_low  = {{(ACC_W-HALF_W){1'b0}}, x_in[HALF_W-1:0]};
        src_mid  = x_in[HALF_W-1:0];
      end
      SRC_YL: begin
        src_full = half_up(y_in[HALF_W-1:0]);
        src_low  = {{(ACC_W-HALF_W){1'b0}}, y_in[HALF_W-1:0]};
        src_mid  = y_in[HALF_W-1:0];
      end
      SRC_XH: begin
        src_full = half_up(x_in[REG_W-1:HALF_W]);
        src_mid  = x_in[REG_W-1:HALF_W];
      end
      SRC_YH: begin
        src_full = half_up(y_in[REG_W-1:HALF_W]);
        src_mid  = y_in[REG_W-1:HALF_W];
      end
      SRC_X: src_full = {{MID_EXT{x_in[REG_W-1]}}, x_in};
      SRC_Y: src_full = {{MID_EXT{y_in[REG_W-1]}}, y_in};
      SRC_A: begin
        src_full = acc_a;
        src_mid  = acc_a[REG_W-1:HALF_W];
      end
      SRC_B: begin
        src_full = acc_b;
        src_mid  = acc_b[REG_W-1:HALF_W];
      end
      SRC_P: src_full = prod_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_acc_alu_core.sv
module dual_acc_alu_core
  import dual_acc_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [ACC_W-1:0]  d_val,
  input  logic [ACC_W-1:0]  src_full,
  input  logic [ACC_W-1:0]  src_low,
  input  logic [HALF_W-1:0] src_mid,
  output logic [ACC_W-1:0]  result,
  output logic              wr_acc,
  output logic              wr_flg
);
  localparam logic [ACC_W-1:0] STEP_LO  = ACC_W'(1);
  localparam logic [ACC_W-1:0] STEP_MID = ACC_W'(1) << HALF_W;
  localparam logic [ACC_W-1:0] HALFWAY  = ACC_W'(1) << (HALF_W-1);

  logic [ACC_W-1:0]  rnd_bias;
  logic [ACC_W-1:0]  rnd_sum;
  logic [HALF_W-1:0] mid_in;

  assign mid_in   = d_val[REG_W-1:HALF_W];
  assign rnd_bias = ((d_val[HALF_W-1:0] == HALFWAY[HALF_W-1:0]) && !d_val[HALF_W])
                    ? '0 : HALFWAY;
  assign rnd_sum  = d_val + rnd_bias;

  always_comb begin
    result = d_val;
    wr_acc = 1'b1;
    wr_flg = 1'b1;
    case (op)
      OP_ADD:  result = d_val + src_full;
      OP_ADDL: result = d_val + src_low;
      OP_SUB:  result = d_val - src_full;
      OP_CMP: begin
        result = d_val - src_full;
        wr_acc = 1'b0;
      end
      OP_MOVE: result = src_full;
      OP_INC:  result = d_val + STEP_LO;
      OP_INCM: result = d_val + STEP_MID;
      OP_DEC:  result = d_val - STEP_LO;
      OP_DECM: result = d_val - STEP_MID;
      OP_ABS:  result = d_val[ACC_W-1] ? ('0 - d_val) : d_val;
      OP_NEG:  result = '0 - d_val;
      OP_RND:  result = {rnd_sum[ACC_W-1:HALF_W], {HALF_W{1'b0}}};
      OP_CLR:  result = '0;
      OP_TST:  wr_acc = 1'b0;
      OP_NOT:  result = {d_val[ACC_W-1:REG_W], ~mid_in,           d_val[HALF_W-1:0]};
      OP_AND:  result = {d_val[ACC_W-1:REG_W], mid_in & src_mid,  d_val[HALF_W-1:0]};
      OP_OR:   result = {d_val[ACC_W-1:REG_W], mid_in | src_mid,  d_val[HALF_W-1:0]};
      OP_XOR:  result = {d_val[ACC_W-1:REG_W], mid_in ^ src_mid,  d_val[HALF_W-1:0]};
      default: begin
        wr_acc = 1'b0;
        wr_flg = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dual_acc_alu_flags.sv
module dual_acc_alu_flags
  import dual_acc_alu_pkg::*;
(
  input  logic [ACC_W-1:0] value,
  output logic [FLG_W-1:0] status
);
  logic [EXT_W:0] top_bits;
  assign top_bits = value[ACC_W-1:REG_W-1];

  always_comb begin
    status[0] = (value == '0);
    status[1] = value[ACC_W-1];
    status[2] = !((&top_bits) || !(|top_bits));
    status[3] = (value[REG_W-1] == value[REG_W-2]);
  end
endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import dual_acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [OP_W-1:0]   op,
  input  logic              dst,
  input  logic [SRC_W-1:0]  src,
  input  logic [REG_W-1:0]  x_in,
  input  logic [REG_W-1:0]  y_in,
  input  logic [ACC_W-1:0]  prod_in,
  output logic [ACC_W-1:0]  acc_a,
  output logic [ACC_W-1:0]  acc_b,
  output logic [FLG_W-1:0]  flags
);
  logic [ACC_W-1:0]  src_full, src_low, d_val, result;
  logic [HALF_W-1:0] src_mid;
  logic              wr_acc, wr_flg;
  logic [FLG_W-1:0]  status;
  logic [ACC_W-1:0]  a_nxt, b_nxt;
  logic [FLG_W-1:0]  f_nxt;

  dual_acc_alu_align u_align (
    .src(src), .x_in(x_in), .y_in(y_in), .prod_in(prod_in),
    .acc_a(acc_a), .acc_b(acc_b),
    .src_full(src_full), .src_low(src_low), .src_mid(src_mid)
  );

  assign d_val = dst ? acc_b : acc_a;

  dual_acc_alu_core u_core (
    .op(op), .d_val(d_val), .src_full(src_full), .src_low(src_low),
    .src_mid(src_mid), .result(result), .wr_acc(wr_acc), .wr_flg(wr_flg)
  );

  dual_acc_alu_flags u_flags (.value(result), .status(status));

  always_comb begin
    a_nxt = acc_a;
    b_nxt = acc_b;
    f_nxt = flags;
    if (en) begin
      if (wr_acc && !dst) a_nxt = result;
      if (wr_acc &&  dst) b_nxt = result;
      if (wr_flg)         f_nxt = status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      flags <= '0;
    end else begin
      acc_a <= a_nxt;
      acc_b <= b_nxt;
      flags <= f_nxt;
    end
  end
endmodule

// File: rtl/dual_acc_alu_chk.sv
module dual_acc_alu_chk
  import dual_acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [OP_W-1:0]   op,
  input logic              dst,
  input logic [ACC_W-1:0]  acc_a,
  input logic [ACC_W-1:0]  acc_b,
  input logic [FLG_W-1:0]  flags
);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_a) && $stable(acc_b) && $stable(flags)));

  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_CMP) |=> ($stable(acc_a) && $stable(acc_b)));

  a_r13_other_acc_a: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dst) |=> $stable(acc_a));

  a_r13_other_acc_b: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dst) |=> $stable(acc_b));

  a_r9_rnd_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dst && op == OP_RND) |=> (acc_a[HALF_W-1:0] == '0));

  a_r10_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dst && op == OP_CLR) |=> (acc_a == '0 && flags[0]));

  a_r11_logic_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dst && op >= OP_NOT && op <= OP_XOR) |=>
      (acc_a[ACC_W-1:REG_W] == $past(acc_a[ACC_W-1:REG_W]) &&
       acc_a[HALF_W-1:0] == $past(acc_a[HALF_W-1:0])));
endmodule

bind dual_acc_alu dual_acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .dst(dst),
  .acc_a(acc_a), .acc_b(acc_b), .flags(flags)
);

// File: tb/test_dual_acc_alu.sv
`timescale 1ns/1ps
module test_dual_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  op = '0;
  logic        dst = 1'b0;
  logic [3:0]  src = '0;
  logic [31:0] x_in = '0, y_in = '0;
  logic [39:0] prod_in = '0;
  logic [39:0] acc_a, acc_b;
  logic [3:0]  flags;

  int errors = 0;
  int checks = 0;
  logic [39:0] ea, eb;
  logic [3:0]  ef;

  always #2.5 clk = ~clk;

  dual_acc_alu i_dual_acc_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .dst(dst), .src(src),
    .x_in(x_in), .y_in(y_in), .prod_in(prod_in),
    .acc_a(acc_a), .acc_b(acc_b), .flags(flags)
  );

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [39:0] m_src(logic [3:0] s, logic [31:0] xv, logic [31:0] yv,
                                        logic [39:0] pv, logic [39:0] av, logic [39:0] bv);
    case (s)
      4'd0: return {{8{xv[15]}}, xv[15:0], 16'h0};
      4'd1: return {{8{yv[15]}}, yv[15:0], 16'h0};
      4'd2: return {{8{xv[31]}}, xv[31:16], 16'h0};
      4'd3: return {{8{yv[31]}}, yv[31:16], 16'h0};
      4'd4: return {{8{xv[31]}}, xv};
      4'd5: return {{8{yv[31]}}, yv};
      4'd6: return av;
      4'd7: return bv;
      4'd8: return pv;
      default: return 40'h0;
    endcase
  endfunction

  function automatic logic [15:0] m_mid(logic [3:0] s, logic [31:0] xv, logic [31:0] yv,
                                        logic [39:0] av, logic [39:0] bv);
    case (s)
      4'd0: return xv[15:0];
      4'd1: return yv[15:0];
      4'd2: return xv[31:16];
      4'd3: return yv[31:16];
      4'd6: return av[31:16];
      4'd7: return bv[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] m_flags(logic [39:0] r);
    logic [3:0] f;
    f[0] = (r == 40'h0);
    f[1] = r[39];
    f[2] = (r[39:31] != 9'h000) && (r[39:31] != 9'h1FF);
    f[3] = (r[31] == r[30]);
    return f;
  endfunction

  function automatic string m_tag(logic [4:0] o);
    case (o)
      5'd0, 5'd2: return "R3";
      5'd1: return "R4";
      5'd4: return "R5";
      5'd3: return "R6";
      5'd5, 5'd6, 5'd7, 5'd8: return "R7";
      5'd9, 5'd10: return "R8";
      5'd11: return "R9";
      5'd12, 5'd13: return "R10";
      5'd14, 5'd15, 5'd16, 5'd17: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic e, logic [4:0] o, logic d, logic [3:0] s,
                      logic [31:0] xv, logic [31:0] yv, logic [39:0] pv, string tg);
    logic [39:0] dv, sv, r, lo, rs;
    logic [15:0] mv, md;
    logic        w, fw;
    string       t;
    @(negedge clk);
    en = e; op = o; dst = d; src = s; x_in = xv; y_in = yv; prod_in = pv;
    dv = d ? eb : ea;
    sv = m_src(s, xv, yv, pv, ea, eb);
    mv = m_mid(s, xv, yv, ea, eb);
    md = dv[31:16];
    lo = (s == 4'd0) ? {24'h0, xv[15:0]} : (s == 4'd1) ? {24'h0, yv[15:0]} : 40'h0;
    w = 1'b1; fw = 1'b1; r = dv;
    case (o)
      5'd0:  r = dv + sv;
      5'd1:  r = dv + lo;
      5'd2:  r = dv - sv;
      5'd3:  begin r = dv - sv; w = 1'b0; end
      5'd4:  r = sv;
      5'd5:  r = dv + 40'h1;
      5'd6:  r = dv + 40'h10000;
      5'd7:  r = dv - 40'h1;
      5'd8:  r = dv - 40'h10000;
      5'd9:  r = dv[39] ? -dv : dv;
      5'd10: r = -dv;
      5'd11: begin
        rs = (dv[15:0] == 16'h8000 && !dv[16]) ? dv : dv + 40'h8000;
        r = {rs[39:16], 16'h0};
      end
      5'd12: r = 40'h0;
      5'd13: w = 1'b0;
      5'd14: r = {dv[39:32], ~md, dv[15:0]};
      5'd15: r = {dv[39:32], md & mv, dv[15:0]};
      5'd16: r = {dv[39:32], md | mv, dv[15:0]};
      5'd17: r = {dv[39:32], md ^ mv, dv[15:0]};
      default: begin w = 1'b0; fw = 1'b0; end
    endcase
    if (e) begin
      if (w && !d) ea = r;
      if (w && d)  eb = r;
      if (fw)      ef = m_flags(r);
    end
    t = (tg != "") ? tg : (e ? m_tag(o) : "R2");
    @(negedge clk);
    en = 1'b0;
    check(t, "acc_a", acc_a, ea);
    check(t, "acc_b", acc_b, eb);
    check((fw && e) ? "R12" : t, "flags", {36'h0, flags}, {36'h0, ef});
  endtask

  initial begin
    ea = '0; eb = '0; ef = '0;
    repeat (3) @(negedge clk);
    check("R1", "acc_a reset", acc_a, 40'h0);
    check("R1", "acc_b reset", acc_b, 40'h0);
    check("R1", "flags reset", {36'h0, flags}, 40'h0);
    rst_n = 1'b1;

    // R3 alignment: negative high half, full register, product
    step(1, 5'd0, 0, 4'd2, 32'h8001_0000, 0, 0, "R3");
    step(1, 5'd0, 0, 4'd4, 32'hFFFF_FFFE, 0, 0, "R3");
    step(1, 5'd2, 1, 4'd8, 0, 0, 40'hF0_1234_5678, "R3");
    // R4 add-low zero-extended
    step(1, 5'd1, 1, 4'd1, 0, 32'h0000_FFFF, 0, "R4");
    // R6 compare leaves accumulators
    step(1, 5'd3, 0, 4'd7, 0, 0, 0, "R6");
    // R13 wrap at top of positive range
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'h7F_FFFF_FFFF, "R5");
    step(1, 5'd5, 0, 4'd0, 0, 0, 0, "R13");
    step(1, 5'd7, 0, 4'd0, 0, 0, 0, "R13");
    step(1, 5'd6, 0, 4'd0, 0, 0, 0, "R7");
    // R9 rounding corners
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'h00_1234_8000, "R5");
    step(1, 5'd11, 0, 4'd0, 0, 0, 0, "R9");
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'h00_1235_8000, "R5");
    step(1, 5'd11, 0, 4'd0, 0, 0, 0, "R9");
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'h00_1234_8001, "R5");
    step(1, 5'd11, 0, 4'd0, 0, 0, 0, "R9");
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'h00_1234_7FFF, "R5");
    step(1, 5'd11, 0, 4'd0, 0, 0, 0, "R9");
    // R8 abs of negative, neg
    step(1, 5'd4, 1, 4'd5, 0, 32'h8000_0000, 0, "R5");
    step(1, 5'd9, 1, 4'd0, 0, 0, 0, "R8");
    step(1, 5'd10, 1, 4'd0, 0, 0, 0, "R8");
    // R11 logical keep outer bits
    step(1, 5'd4, 0, 4'd8, 0, 0, 40'hA5_1234_5678, "R5");
    step(1, 5'd14, 0, 4'd0, 0, 0, 0, "R11");
    step(1, 5'd17, 0, 4'd2, 32'hFFFF_0000, 0, 0, "R11");
    // R10 test and clear
    step(1, 5'd13, 0, 4'd0, 0, 0, 0, "R10");
    step(1, 5'd12, 1, 4'd0, 0, 0, 0, "R10");
    // R2 unused code and disabled enable
    step(1, 5'd25, 0, 4'd0, 0, 0, 0, "R2");
    step(0, 5'd12, 0, 4'd0, 0, 0, 0, "R2");

    // random mix, fixed seed
    void'($urandom(32'h1357_2468));
    for (int i = 0; i < 600; i++) begin
      logic [4:0] ro;
      logic       re;
      ro = 5'($urandom_range(0, 19));
      re = ($urandom_range(0, 9) != 0);
      step(re, ro, 1'($urandom), 4'($urandom_range(0, 10)),
           $urandom, $urandom, {8'($urandom), 32'($urandom)}, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule